// File: doc/BRIEF.md
# Rewindable Synchronous FIFO with Selectable Read Semantics

This block is a single-clock FIFO buffer. Its read behaviour is chosen once, at master reset, from a mode input. In standard mode a word is moved to the registered read output only when the consumer asks for it. In fall-through mode the oldest unread word is placed on the read output without any request, and a read enable consumes it. The two status outputs change meaning with the mode. In standard mode they are an empty flag and a full flag. In fall-through mode they are a data-valid flag and a room-to-write flag.

A consumer can record its read position with a mark request and later rewind to that position with a retransmit request, which replays every word from the mark onward. Storage is counted from the mark, not from the read pointer, so a marked word is never overwritten. A master reset sets up the mode, a zero mark and empty storage. A partial reset empties the buffer and keeps the mode. A consumer that does not need replay keeps the mark request high while it reads, so that the mark follows its read position.

Top module: `rtxfifo`

## Requirements
- R1: The read mode is taken from `modeSel` (0 = standard, 1 = fall-through) only in cycles where `mstRst` is high. Changing `modeSel` at any other time has no effect.
- R2: In standard mode, `emptyOrValid` is 1 exactly when no unread word remains, and `fullOrRoom` is 1 exactly when DEPTH words lie between the mark and the write position.
- R3: In fall-through mode, `emptyOrValid` is 1 exactly when `rdData` holds an unread head word, and `fullOrRoom` is 1 exactly when a write would be accepted.
- R4: A master reset, sampled on a clock edge, empties the buffer, sets the read, write and mark positions to location zero, and drives `rdData` to all zeros from the next cycle.
- R5: A partial reset has the same effect as R4 but keeps the latched mode.
- R6: In standard mode, an accepted read places the next word, in write order, on `rdData` one cycle after the `rdEn` edge. `rdData` holds its value otherwise.
- R7: In fall-through mode, a word written into an empty buffer appears on `rdData`, with `emptyOrValid` high, one cycle after the write, without `rdEn`. A read with `emptyOrValid` high consumes the head, and the next word appears one cycle later.
- R8: `markReq` records the position of the oldest unread word (the displayed head in fall-through mode). `rewindReq` returns reading to the most recent mark, which stays valid. A rewind takes priority over a read or a mark in the same cycle.
- R9: With no mark taken since the last reset, a rewind returns reading to location zero.
- R10: A write is refused when DEPTH words lie between the mark and the write position, even if they have been read. Moving the mark forward frees space.
- R11: A write while full and a read while empty (standard) or without valid data (fall-through) are ignored, and neither position changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mstRst | input | 1 | Synchronous master reset, latches the mode |
| partRst | input | 1 | Synchronous partial reset, keeps the mode |
| modeSel | input | 1 | Mode sampled during master reset: 0 standard, 1 fall-through |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Registered read data |
| markReq | input | 1 | Record the current read position |
| rewindReq | input | 1 | Return reading to the recorded position |
| emptyOrValid | output | 1 | Empty flag (standard) or data-valid flag (fall-through) |
| fullOrRoom | output | 1 | Full flag (standard) or room flag (fall-through) |

## Verification
The assertions check on every cycle the invariants that hold between the positions. Unread words never exceed the words held since the mark, and the held words never exceed DEPTH. The fall-through valid bit always agrees with the positions, the mode stays put outside master reset, and a write while full leaves the write position alone. The ordering of the data, the one-cycle latency in each mode, the replay content after a rewind and the mode kept through a partial reset can only be shown by the bench. It compares the outputs with a reference model under directed and random traffic.

// File: rtl/rtxfifo_pkg.sv
package rtxfifo_pkg;
  // Strobes from control to datapath for one clock cycle
  typedef struct packed {
    logic wrGo;     // store wrData at the write index
    logic loadOut;  // reload the output register
    logic useFwd;   // take the output word from wrData instead of storage
    logic clrOut;   // force the output register to zero
  } dpStrobes_t;
endpackage

// File: rtl/rtxfifo_ctrl.sv
module rtxfifo_ctrl
  import rtxfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          mstRst,
  input  logic          partRst,
  input  logic          modeSel,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          markReq,
  input  logic          rewindReq,
  output dpStrobes_t    strobes,
  output logic [AW-1:0] wrIdx,
  output logic [AW-1:0] rdIdx,
  output logic          emptyOrValid,
  output logic          fullOrRoom
);
  logic          fwftMode;
  logic [PW-1:0] wrPtr, rdPtr, markPtr;
  logic [PW-1:0] wrPtrNext, rdPtrNext;
  logic [PW-1:0] unread, held;
  logic          outValid;
  logic          anyRst, isEmpty, isFull;
  logic          wrGo, popOk, rdGo, markGo, validNext;

  assign anyRst  = mstRst | partRst;
  assign unread  = wrPtr - rdPtr;
  assign held    = wrPtr - markPtr;
  assign isEmpty = (unread == '0);
  assign isFull  = (held == PW'(DEPTH));

  assign wrGo   = wrEn && !isFull && !anyRst;
  assign popOk  = fwftMode ? (rdEn && outValid) : (rdEn && !isEmpty);
  assign rdGo   = popOk && !rewindReq && !anyRst;
  assign markGo = markReq && !rewindReq;

  always_comb begin
    if (rewindReq)  rdPtrNext = markPtr;
    else if (rdGo)  rdPtrNext = rdPtr + PW'(1);
    else            rdPtrNext = rdPtr;
  end
  assign wrPtrNext = wrGo ? wrPtr + PW'(1) : wrPtr;
  assign validNext = (wrPtrNext != rdPtrNext);

  always_ff @(posedge clk) begin
    if (mstRst) fwftMode <= modeSel;
  end

  always_ff @(posedge clk) begin
    if (anyRst) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      markPtr  <= '0;
      outValid <= 1'b0;
    end else begin
      wrPtr    <= wrPtrNext;
      rdPtr    <= rdPtrNext;
      if (markGo) markPtr <= rdPtr;
      outValid <= fwftMode && validNext;
    end
  end

  always_comb begin
    strobes.wrGo    = wrGo;
    strobes.clrOut  = anyRst;
    strobes.loadOut = fwftMode ? validNext : rdGo;
    strobes.useFwd  = fwftMode && wrGo && (wrPtr[AW-1:0] == rdPtrNext[AW-1:0]);
  end
  assign wrIdx = wrPtr[AW-1:0];
  assign rdIdx = fwftMode ? rdPtrNext[AW-1:0] : rdPtr[AW-1:0];

  assign emptyOrValid = fwftMode ? outValid : isEmpty;
  assign fullOrRoom   = fwftMode ? !isFull : isFull;

  // R4
  rst_clear_chk: assert property (@(posedge clk)
    anyRst |=> (wrPtr == '0 && rdPtr == '0 && markPtr == '0 && !outValid));
  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (mstRst)
    !mstRst |=> $stable(fwftMode));
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (anyRst)
    (held <= PW'(DEPTH)) && (unread <= held));
  // R11
  full_hold_chk: assert property (@(posedge clk) disable iff (anyRst)
    (isFull && wrEn) |=> $stable(wrPtr));
  // R8
  rewind_chk: assert property (@(posedge clk) disable iff (anyRst)
    rewindReq |=> (rdPtr == $past(markPtr)));
  // R3
  fwft_valid_chk: assert property (@(posedge clk) disable iff (anyRst)
    fwftMode |-> (outValid == (wrPtr != rdPtr)));
endmodule

// File: rtl/rtxfifo_datapath.sv
module rtxfifo_datapath
  import rtxfifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  dpStrobes_t        strobes,
  input  logic [AW-1:0]     wrIdx,
  input  logic [AW-1:0]     rdIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrGo) store[wrIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobes.clrOut)       rdData <= '0;
    else if (strobes.loadOut) rdData <= strobes.useFwd ? wrData : store[rdIdx];
  end
endmodule

// File: rtl/rtxfifo.sv
module rtxfifo
  import rtxfifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              mstRst,
  input  logic              partRst,
  input  logic              modeSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              markReq,
  input  logic              rewindReq,
  output logic              emptyOrValid,
  output logic              fullOrRoom
);
  dpStrobes_t    strobes;
  logic [AW-1:0] wrIdx, rdIdx;

  rtxfifo_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .mstRst(mstRst), .partRst(partRst), .modeSel(modeSel),
    .wrEn(wrEn), .rdEn(rdEn), .markReq(markReq), .rewindReq(rewindReq),
    .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .emptyOrValid(emptyOrValid), .fullOrRoom(fullOrRoom)
  );

  rtxfifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dp (
    .clk(clk), .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/rtxfifo_test.sv
module rtxfifo_test;
  localparam int DW = 16;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic mstRst = 1'b1, partRst = 1'b0, modeSel = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, markReq = 1'b0, rewindReq = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic emptyOrValid, fullOrRoom;

  rtxfifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .mstRst(mstRst), .partRst(partRst), .modeSel(modeSel),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .markReq(markReq), .rewindReq(rewindReq),
    .emptyOrValid(emptyOrValid), .fullOrRoom(fullOrRoom)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "R4";

  // reference model state
  int mWr = 0, mRd = 0, mMark = 0;
  bit mMode = 0, mValid = 0;
  logic [DW-1:0] mOut = '0;
  logic [DW-1:0] hist [1024];

  function automatic bit expA();
    return mMode ? mValid : (mWr == mRd);
  endfunction
  function automatic bit expB();
    bit full = (mWr - mMark) == DEPTH;
    return mMode ? !full : full;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelStep(bit w, logic [DW-1:0] d, bit r, bit mk, bit rw,
                           bit mr, bit pr, bit sel);
    bit full, empty, wgo, rgo;
    int newRd;
    if (mr) mMode = sel;
    if (mr || pr) begin
      mWr = 0; mRd = 0; mMark = 0; mOut = '0; mValid = 0;
      return;
    end
    full  = (mWr - mMark) == DEPTH;
    empty = (mWr == mRd);
    wgo   = w && !full;
    rgo   = (mMode ? (r && mValid) : (r && !empty)) && !rw;
    newRd = rw ? mMark : (rgo ? mRd + 1 : mRd);
    if (mk && !rw) mMark = mRd;
    if (!mMode && rgo) mOut = hist[mRd % 1024];
    if (wgo) begin hist[mWr % 1024] = d; mWr++; end
    if (mMode) begin
      if (mWr != newRd) begin mOut = hist[newRd % 1024]; mValid = 1; end
      else mValid = 0;
    end
    mRd = newRd;
  endtask

  task automatic step(bit w, logic [DW-1:0] d, bit r, bit mk, bit rw,
                      bit mr, bit pr, bit sel);
    @(negedge clk);
    wrEn = w; wrData = d; rdEn = r; markReq = mk; rewindReq = rw;
    mstRst = mr; partRst = pr; modeSel = sel;
    @(posedge clk);
    modelStep(w, d, r, mk, rw, mr, pr, sel);
    #5;
    chk(emptyOrValid === expA(), "emptyOrValid", int'(emptyOrValid), int'(expA()));
    chk(fullOrRoom === expB(), "fullOrRoom", int'(fullOrRoom), int'(expB()));
    if (!mMode || mValid) chk(rdData === mOut, "rdData", int'(rdData), int'(mOut));
  endtask

  task automatic idle(bit sel = 0); step(0, '0, 0, 0, 0, 0, 0, sel); endtask
  task automatic wr(logic [DW-1:0] d); step(1, d, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd(); step(0, '0, 1, 0, 0, 0, 0, 0); endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R4: master reset into standard mode
    tag = "R4";
    step(0, '0, 0, 0, 0, 1, 0, 0);
    chk(emptyOrValid === 1'b1 && fullOrRoom === 1'b0, "reset flags", int'({emptyOrValid, fullOrRoom}), 2);
    chk(rdData === '0, "reset rdData", int'(rdData), 0);

    // R1: modeSel moving outside master reset is ignored
    tag = "R1";
    idle(1);
    step(1, 16'h0100, 0, 0, 0, 0, 0, 1);
    idle(1);
    chk(emptyOrValid === 1'b0 && rdData === '0, "still standard", int'(rdData), 0);

    // R6 / R2: standard reads with one-cycle latency
    tag = "R6";
    for (int i = 1; i < DEPTH; i++) wr(DW'(16'h0100 + i));
    tag = "R10";
    chk(fullOrRoom === 1'b1, "full at DEPTH", int'(fullOrRoom), 1);
    tag = "R11";
    wr(16'hDEAD);
    tag = "R6";
    rd();
    chk(rdData === 16'h0100, "first word", int'(rdData), 'h100);
    for (int i = 1; i < DEPTH; i++) rd();
    chk(rdData === 16'h010F, "last word", int'(rdData), 'h10F);
    tag = "R11";
    rd();
    chk(rdData === 16'h010F, "read while empty ignored", int'(rdData), 'h10F);
    // R10: implicit mark at zero still holds all words
    tag = "R10";
    chk(fullOrRoom === 1'b1, "mark keeps space", int'(fullOrRoom), 1);
    // R9: rewind without a mark returns to location zero
    tag = "R9";
    step(0, '0, 0, 0, 1, 0, 0, 0);
    rd();
    chk(rdData === 16'h0100, "replay from zero", int'(rdData), 'h100);
    // R10: moving the mark frees space
    tag = "R10";
    step(0, '0, 0, 1, 0, 0, 0, 0);
    chk(fullOrRoom === 1'b0, "space after mark", int'(fullOrRoom), 0);

    // R5: partial reset keeps standard mode even with modeSel high
    tag = "R5";
    step(0, '0, 0, 0, 0, 0, 1, 1);
    chk(emptyOrValid === 1'b1 && rdData === '0, "partial reset", int'(rdData), 0);
    step(1, 16'h0A0A, 0, 0, 0, 0, 0, 1);
    idle();
    chk(rdData === '0, "no fall-through after partial reset", int'(rdData), 0);

    // R7 / R3: master reset into fall-through mode
    tag = "R7";
    step(0, '0, 0, 0, 0, 1, 0, 1);
    chk(emptyOrValid === 1'b0 && fullOrRoom === 1'b1, "fwft reset flags", int'({emptyOrValid, fullOrRoom}), 1);
    wr(16'h0200);
    chk(emptyOrValid === 1'b1 && rdData === 16'h0200, "head falls through", int'(rdData), 'h200);
    for (int i = 1; i < 6; i++) wr(DW'(16'h0200 + i));
    rd(); rd();
    chk(rdData === 16'h0202, "after two pops", int'(rdData), 'h202);
    // R8: mark the head, pop, rewind; rewind beats a read
    tag = "R8";
    step(0, '0, 0, 1, 0, 0, 0, 0);
    rd(); rd();
    chk(rdData === 16'h0204, "advanced", int'(rdData), 'h204);
    step(0, '0, 1, 0, 1, 0, 0, 0);
    chk(rdData === 16'h0202, "rewound to mark", int'(rdData), 'h202);
    step(0, '0, 0, 1, 1, 0, 0, 0);
    rd();
    step(0, '0, 0, 0, 1, 0, 0, 0);
    chk(rdData === 16'h0202, "mark ignored during rewind", int'(rdData), 'h202);

    // random traffic in both modes against the model
    void'($urandom(32'h5EED));
    for (int seg = 0; seg < 8; seg++) begin
      bit sel = seg[0];
      tag = sel ? "R3" : "R2";
      step(0, '0, 0, 0, 0, 1, 0, sel);
      for (int c = 0; c < 600; c++) begin
        step(($urandom % 3) != 0, DW'($urandom), ($urandom % 2) == 0,
             ($urandom % 4) == 0, ($urandom % 40) == 0, 0,
             ($urandom % 300) == 0, ($urandom % 2) == 0);
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule